// File: doc/BRIEF.md
# SPI Inter-Frame Gap Timer

This block measures the idle gap an SPI master leaves between releasing chip select at the end of one frame and driving it again for the next. It runs on the system clock. A one-cycle `frame_end` pulse starts the timer. When the gap has elapsed and lines up with the serial clock, a one-cycle `gap_done` pulse allows the next chip-select assertion. The serial clock generator supplies `sck_edge`, a one-cycle strobe in each SCK period that marks the active edge.

The gap length is an odd prescaler multiplied by a power-of-two scaler, both chosen by small codes. The gap source depends on two mode inputs. With the serial clock gated between frames, the programmed codes set the gap. With a free-running serial clock, the gap is one SCK period. If `gap_prog_en` is also set, the programmed codes apply again. The programmed gap may end partway through an SCK period. In that case completion waits for the next active-edge strobe. The block captures the codes and mode inputs on the `frame_end` cycle, so later changes to them do not affect a gap already running.

Top module: `spi_gap_timer`

## Requirements
- R1: The gap length N, in system clocks, is P×S. P comes from `gap_pre_sel` code c as 2c+1 (00→1, 01→3, 10→5, 11→7). S comes from `gap_exp_sel` code n as 2^(n+1) (0→2, 4→32, 14→32768, 15→65536).
- R2: When `sck_free_run` is 0, N is taken from the codes as in R1. Mode inputs and codes are sampled on the clock edge that samples `frame_end`.
- R3: When `sck_free_run` is 1 and `gap_prog_en` is 0, N is one SCK period (parameter `SCK_PERIOD`, default 4 system clocks), whatever the codes are.
- R4: When `sck_free_run` is 1 and `gap_prog_en` is 1, N is again taken from the codes as in R1.
- R5: Let edge k be the rising clock edge that samples `frame_end` high. `gap_done` is high in the cycle after edge m. Edge m is the first rising edge with m ≥ k+N+1 at which `sck_edge` is sampled high.
- R6: `gap_done` lasts exactly one cycle, and each started gap gives at most one pulse.
- R7: A `frame_end` that arrives while a gap is running restarts the timer with the current inputs. The interrupted gap never produces a pulse.
- R8: A synchronous, active-high `rst` clears the timer. `gap_done` stays low during reset, and no pulse follows reset until a new `frame_end`.
- R9: The counter holds the largest gap, 7×65536 cycles, so the code pair 01/14 (98304 cycles) completes on the exact cycle given by R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gap_pre_sel | input | 2 | Prescaler code |
| gap_exp_sel | input | 4 | Power-of-two scaler code |
| sck_free_run | input | 1 | Serial clock runs continuously between frames |
| gap_prog_en | input | 1 | Use the programmed gap even with a free-running clock |
| frame_end | input | 1 | One-cycle pulse: chip select has just been released |
| sck_edge | input | 1 | One-cycle strobe marking an SCK active edge |
| gap_done | output | 1 | One-cycle pulse: next chip select may be asserted |

## Verification
The only result is the `gap_done` pulse. It is due on the first strobe-sampling edge at least N+1 edges after the edge that took `frame_end`. The bench numbers every rising edge. When it drives `frame_end`, the driver computes the due edge from the codes, the mode and the fixed strobe schedule, then pushes it into a queue. A monitor samples `gap_done` at each falling edge and compares the current edge number with the head of the queue. A pulse with an empty queue counts as a failure. Start times are skewed against the strobe so that every alignment offset occurs.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;

   typedef enum logic {
      GAP_SRC_CODES = 1'b0,
      GAP_SRC_FIXED = 1'b1
   } gap_src_e;

   // width needed to hold the largest gap the codes or the fixed period can ask for
   function automatic int gap_cnt_width(input int pre_w, input int scl_w, input int sck_period);
      longint max_pre;
      longint max_gap;
      int     w;
      max_pre = 2 * ((longint'(1) << pre_w) - 1) + 1;
      max_gap = max_pre << (longint'(1) << scl_w);
      if (longint'(sck_period) > max_gap) max_gap = longint'(sck_period);
      w = 1;
      while ((longint'(1) << w) <= max_gap) w++;
      return w;
   endfunction

endpackage

// File: rtl/gap_src_sel.sv
module gap_src_sel
   import spi_gap_pkg::*;
(
   input  logic     free_run_i,
   input  logic     prog_en_i,
   output gap_src_e src_o
);
   always_comb begin
      if (free_run_i && !prog_en_i) src_o = GAP_SRC_FIXED;
      else                          src_o = GAP_SRC_CODES;
   end
endmodule

// File: rtl/gap_decode.sv
module gap_decode
   import spi_gap_pkg::*;
#(
   parameter int PRE_W      = 2,
   parameter int SCL_W      = 4,
   parameter int CNT_W      = 19,
   parameter int SCK_PERIOD = 4,
   parameter bit SHIFT_MUL  = 1'b1
) (
   input  logic [PRE_W-1:0] pre_i,
   input  logic [SCL_W-1:0] exp_i,
   input  gap_src_e         src_i,
   output logic [CNT_W-1:0] gap_o
);
   localparam int SH_W = SCL_W + 1;

   logic [PRE_W:0]     pre_val;
   logic [SH_W-1:0]    shamt;
   logic [CNT_W-1:0]   prog_gap;

   assign pre_val = {pre_i, 1'b1};
   assign shamt   = {1'b0, exp_i} + SH_W'(1);

   generate
      if (SHIFT_MUL) begin : g_shift
         assign prog_gap = CNT_W'(pre_val) << shamt;
      end else begin : g_mult
         logic [CNT_W-1:0] scale;
         assign scale    = CNT_W'(1) << shamt;
         assign prog_gap = CNT_W'(pre_val) * scale;
      end
   endgenerate

   always_comb begin
      if (src_i == GAP_SRC_FIXED) gap_o = CNT_W'(SCK_PERIOD);
      else                        gap_o = prog_gap;
   end
endmodule

// File: rtl/gap_count.sv
module gap_count #(
   parameter int CNT_W = 19
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [CNT_W-1:0] gap_i,
   input  logic             sck_edge_i,
   output logic             done_o
);
   logic [CNT_W-1:0] remain;
   logic             armed;

   always_ff @(posedge clk) begin
      if (rst) begin
         remain <= '0;
         armed  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (load_i) begin
            remain <= gap_i;
            armed  <= 1'b1;
         end else if (armed) begin
            if (remain != '0) begin
               remain <= remain - CNT_W'(1);
            end else if (sck_edge_i) begin
               armed  <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer
   import spi_gap_pkg::*;
#(
   parameter int PRE_W      = 2,
   parameter int SCL_W      = 4,
   parameter int SCK_PERIOD = 4,
   parameter bit SHIFT_MUL  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PRE_W-1:0] gap_pre_sel,
   input  logic [SCL_W-1:0] gap_exp_sel,
   input  logic             sck_free_run,
   input  logic             gap_prog_en,
   input  logic             frame_end,
   input  logic             sck_edge,
   output logic             gap_done
);
   localparam int CNT_W = gap_cnt_width(PRE_W, SCL_W, SCK_PERIOD);

   if (PRE_W < 1 || PRE_W > 3) begin : g_bad_pre
      $error("spi_gap_timer: PRE_W must be 1..3");
   end
   if (SCL_W < 1 || SCL_W > 5) begin : g_bad_scl
      $error("spi_gap_timer: SCL_W must be 1..5");
   end
   if (SCK_PERIOD < 1) begin : g_bad_sck
      $error("spi_gap_timer: SCK_PERIOD must be at least 1");
   end

   gap_src_e         src;
   logic [CNT_W-1:0] gap_len;

   gap_src_sel u_src (
      .free_run_i (sck_free_run),
      .prog_en_i  (gap_prog_en),
      .src_o      (src)
   );

   gap_decode #(
      .PRE_W      (PRE_W),
      .SCL_W      (SCL_W),
      .CNT_W      (CNT_W),
      .SCK_PERIOD (SCK_PERIOD),
      .SHIFT_MUL  (SHIFT_MUL)
   ) u_dec (
      .pre_i (gap_pre_sel),
      .exp_i (gap_exp_sel),
      .src_i (src),
      .gap_o (gap_len)
   );

   gap_count #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .load_i     (frame_end),
      .gap_i      (gap_len),
      .sck_edge_i (sck_edge),
      .done_o     (gap_done)
   );
endmodule

// File: rtl/gap_timer_chk.sv
module gap_timer_chk #(
   parameter int PRE_W      = 2,
   parameter int SCL_W      = 4,
   parameter int SCK_PERIOD = 4
) (
   input logic             clk,
   input logic             rst,
   input logic [PRE_W-1:0] gap_pre_sel,
   input logic [SCL_W-1:0] gap_exp_sel,
   input logic             sck_free_run,
   input logic             gap_prog_en,
   input logic             frame_end,
   input logic             sck_edge,
   input logic             gap_done
);
   logic        c_armed;
   int unsigned c_since;
   int unsigned c_need;

   always_ff @(posedge clk) begin
      if (rst) begin
         c_armed <= 1'b0;
         c_since <= 0;
         c_need  <= 0;
      end else if (frame_end) begin
         c_armed <= 1'b1;
         c_since <= 0;
         if (sck_free_run && !gap_prog_en) c_need <= SCK_PERIOD;
         else c_need <= (2 * int'(gap_pre_sel) + 1) << (int'(gap_exp_sel) + 1);
      end else if (c_armed) begin
         if (c_since != 32'hFFFF_FFFF) c_since <= c_since + 1;
         if (gap_done) c_armed <= 1'b0;
      end
   end

   // R6
   pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
      gap_done |=> !gap_done);

   // R5
   on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      gap_done |-> $past(sck_edge));

   // R1
   min_gap_chk: assert property (@(posedge clk) disable iff (rst)
      gap_done |-> (c_armed && c_since > c_need));

   // R5
   due_chk: assert property (@(posedge clk) disable iff (rst)
      (c_armed && !gap_done && c_since > c_need && sck_edge && !frame_end) |=> gap_done);

   // R8
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> !gap_done);
endmodule

bind spi_gap_timer gap_timer_chk #(
   .PRE_W      (PRE_W),
   .SCL_W      (SCL_W),
   .SCK_PERIOD (SCK_PERIOD)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .gap_pre_sel  (gap_pre_sel),
   .gap_exp_sel  (gap_exp_sel),
   .sck_free_run (sck_free_run),
   .gap_prog_en  (gap_prog_en),
   .frame_end    (frame_end),
   .sck_edge     (sck_edge),
   .gap_done     (gap_done)
);

// File: tb/spi_gap_timer_test.sv
module spi_gap_timer_test;
   localparam int CLK_PERIOD = 10;
   localparam int SCK_DIV    = 4;
   localparam int DRAIN_MAX  = 120000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] gap_pre_sel = '0;
   logic [3:0] gap_exp_sel = '0;
   logic       sck_free_run = 1'b0;
   logic       gap_prog_en = 1'b0;
   logic       frame_end = 1'b0;
   logic       sck_edge;
   logic       gap_done;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   int spurious = 0;
   bit ended = 1'b0;
   int exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   // strobe sampled at every rising edge whose number is a multiple of SCK_DIV
   assign sck_edge = (cyc % SCK_DIV) == (SCK_DIV - 1);

   spi_gap_timer uut (
      .clk          (clk),
      .rst          (rst),
      .gap_pre_sel  (gap_pre_sel),
      .gap_exp_sel  (gap_exp_sel),
      .sck_free_run (sck_free_run),
      .gap_prog_en  (gap_prog_en),
      .frame_end    (frame_end),
      .sck_edge     (sck_edge),
      .gap_done     (gap_done)
   );

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic finish_up();
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   function automatic int gap_len(input int pre, input int scl, input bit fr, input bit pe);
      if (fr && !pe) return SCK_DIV;
      return (2 * pre + 1) << (scl + 1);
   endfunction

   function automatic int due_edge(input int k, input int n);
      int m = k + n + 1;
      while (m % SCK_DIV != 0) m++;
      return m;
   endfunction

   // monitor: compare every pulse against the scoreboard head
   always @(negedge clk) begin
      if (!rst && gap_done) begin
         if (exp_q.size() == 0) begin
            spurious++;
            check(1'b0, "R6 unexpected gap_done edge", cyc, -1);
         end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(cyc == e, t, cyc, e);
         end
      end
   end

   task automatic start_gap(input int pre, input int scl, input bit fr, input bit pe,
                            input string tag);
      @(negedge clk);
      gap_pre_sel  = 2'(pre);
      gap_exp_sel  = 4'(scl);
      sck_free_run = fr;
      gap_prog_en  = pe;
      frame_end    = 1'b1;
      exp_q.push_back(due_edge(cyc + 1, gap_len(pre, scl, fr, pe)));
      tag_q.push_back(tag);
      @(negedge clk);
      frame_end   = 1'b0;
      // R2: codes changed after capture must not matter
      gap_pre_sel = ~gap_pre_sel;
      gap_exp_sel = ~gap_exp_sel;
      gap_prog_en = ~gap_prog_en;
   endtask

   task automatic drain(input string tag);
      int w = 0;
      while (exp_q.size() != 0 && w < DRAIN_MAX) begin
         @(negedge clk);
         w++;
      end
      if (exp_q.size() != 0) begin
         check(1'b0, {tag, " gap_done never arrived"}, 0, 1);
         exp_q.delete();
         tag_q.delete();
      end
      @(negedge clk);
      // R6: pulse lasted one cycle
      check(gap_done == 1'b0, "R6 pulse width", int'(gap_done), 0);
   endtask

   task automatic run_case(input int skew, input int pre, input int scl, input bit fr,
                           input bit pe, input string tag);
      repeat (skew) @(negedge clk);
      start_gap(pre, scl, fr, pe, tag);
      drain(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", cyc, 0);
      finish_up();
   end

   initial begin
      int sp;
      repeat (3) @(negedge clk);
      // R8: quiet during reset
      check(gap_done == 1'b0, "R8 done low in reset", int'(gap_done), 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);

      run_case(0, 0, 0, 1'b0, 1'b0, "R1 codes 00/0 gap 2");
      run_case(1, 1, 4, 1'b0, 1'b0, "R1 R2 codes 01/4 gap 96");
      run_case(2, 3, 1, 1'b0, 1'b0, "R2 codes 11/1 gap 28");
      run_case(3, 2, 2, 1'b0, 1'b0, "R5 codes 10/2 gap 40");
      run_case(1, 1, 0, 1'b0, 1'b0, "R5 codes 01/0 gap 6");
      run_case(0, 3, 5, 1'b1, 1'b0, "R3 free-run fixed gap, codes 11/5");
      run_case(2, 0, 0, 1'b1, 1'b0, "R3 free-run fixed gap, codes 00/0");
      run_case(3, 1, 4, 1'b1, 1'b1, "R4 free-run programmed 01/4");
      run_case(1, 2, 3, 1'b1, 1'b1, "R4 free-run programmed 10/3");

      // R7: restart mid-gap, first gap must not fire
      start_gap(3, 6, 1'b0, 1'b0, "R7 first gap (should be replaced)");
      repeat (30) @(negedge clk);
      exp_q.delete();
      tag_q.delete();
      sp = spurious;
      start_gap(0, 1, 1'b0, 1'b0, "R7 restarted gap 4");
      drain("R7 restarted gap 4");
      repeat (1000) @(negedge clk);
      check(spurious == sp, "R7 no pulse from interrupted gap", spurious, sp);

      // R8: reset mid-gap cancels it
      start_gap(1, 4, 1'b0, 1'b0, "R8 cancelled gap");
      repeat (20) @(negedge clk);
      rst = 1'b1;
      exp_q.delete();
      tag_q.delete();
      repeat (2) @(negedge clk);
      check(gap_done == 1'b0, "R8 done low in mid-gap reset", int'(gap_done), 0);
      rst = 1'b0;
      sp = spurious;
      repeat (150) @(negedge clk);
      check(spurious == sp, "R8 no pulse after reset", spurious, sp);

      // R9: long gap, exact cycle
      run_case(2, 1, 14, 1'b0, 1'b0, "R9 codes 01/14 gap 98304");

      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "R6 scoreboard empty at end", exp_q.size(), 0);
      finish_up();
   end
endmodule